// File: doc/BRIEF.md
# OFDM Frame Airtime Calculator

This block works out how many microseconds one OFDM frame holds the medium. It counts a SIFS gap, the preamble and the data symbols. Each request gives a frame length in bytes, a bit rate in units of 100 kbit/s and a channel bandwidth mode. The block forms the bit count: 22 header bits plus eight bits for each byte. It divides ten times that bit count by the bits carried in one symbol, rounding up, to get the symbol count. It then adds the mode-dependent SIFS and preamble times. The division runs serially, one quotient bit per clock, so a request takes a fixed number of cycles. `start` opens a request and a single-cycle `done` closes it.

A small combinational lookup sits beside the calculator. For a transmit-rate index it returns the rate index used to answer with an acknowledgement. A `ack_high` input selects a table that follows the transmit rate. When `ack_high` is low, the lookup returns one of two base rates.

Top module: `airtime_calc`

## Requirements
- R1: With `bw_mode`=0 (20 MHz), the symbol time is 4 µs, the preamble is 20 µs and SIFS is 16 µs. The duration is SIFS + preamble + 4·N, where N = ceil(10·(22 + 8·len) / (4·rate)).
- R2: With `bw_mode`=1 (40 MHz), the symbol time stays 4 µs, the preamble is 14 µs and SIFS is 8 µs.
- R3: With `bw_mode`=2 (10 MHz), the symbol time is 8 µs, the preamble 40 µs and SIFS 32 µs. With `bw_mode`=3 (5 MHz), they are 16 µs, 80 µs and 64 µs. The symbol time scales the divisor as well as the symbol term.
- R4: The symbol count rounds up whenever the division leaves a remainder. An exact division adds no extra symbol.
- R5: A request with `rate`=0 raises `done` with `err`=1 and `duration`=0 one edge after acceptance. Any request with a nonzero rate gives `err`=0.
- R6: A duration above 65535 is reported as 0xFFFF.
- R7: `start` is accepted on a rising edge while `busy` is low. For a nonzero rate, `busy` is high from the following cycle until `done`. `done` is high for exactly one cycle, LEN_W+9 rising edges after the accepting edge. `duration` and `err` hold their values until the next accepted request completes.
- R8: `start` asserted while `busy` is high is ignored. The result returned is that of the request already in progress.
- R9: With `ack_high`=1, the acknowledgement index maps 0→0, 1..3→1, 4..5→4, 6..7→6 and 8..11→8. Indices 12..15 also map to 8.
- R10: With `ack_high`=0, indices 0..3 map to 0 and all other indices map to 4.
- R11: After reset, `busy`, `done` and `err` are 0 and `duration` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken while idle |
| len_bytes | input | LEN_W | Frame length in bytes |
| rate | input | RATE_W | Bit rate in 100 kbit/s units |
| bw_mode | input | 2 | 0=20 MHz, 1=40 MHz, 2=10 MHz, 3=5 MHz |
| tx_rate_idx | input | 4 | Transmit-rate index for the acknowledgement lookup |
| ack_high | input | 1 | Selects the rate-following acknowledgement table |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request had a zero rate |
| duration | output | DUR_W | Airtime in microseconds, saturated |
| ack_rate_idx | output | 4 | Acknowledgement rate index |

## Verification
The bench sweeps every bandwidth mode against a spread of rates and lengths, including a zero length, so that exact and inexact divisions both occur. An adder that dropped the final increment would come out one symbol time short. One that always added it would run one symbol long on exact quotients. The bench drives the longest frames at the slowest rates in 5 MHz mode to reach saturation. There, a design that truncated instead of clamping would return a small wrapped value. Further checks cover a zero rate, a `start` pulsed in the middle of a division, and a full sweep of both acknowledgement tables. A wrong divide-by-zero path would hang or return a large number. A design that accepted `start` while busy would return the second request's result.

// File: rtl/airtime_calc.sv
module airtime_calc #(
  parameter int LEN_W        = 12,
  parameter int RATE_W       = 10,
  parameter int DUR_W        = 16,
  parameter int PLCP_BITS    = 22,
  parameter int SYM_US       = 4,
  parameter int PRE_US       = 20,
  parameter int PRE_WIDE_US  = 14,
  parameter int SIFS_US      = 16,
  parameter int SIFS_WIDE_US = 8,
  parameter int SIFS_HALF_US = 32,
  parameter int SIFS_QTR_US  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_bytes,
  input  logic [RATE_W-1:0] rate,
  input  logic [1:0]        bw_mode,
  input  logic [3:0]        tx_rate_idx,
  input  logic              ack_high,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DUR_W-1:0]  duration,
  output logic [3:0]        ack_rate_idx
);
  localparam int DVD_W = LEN_W + 8;
  localparam int DSR_W = RATE_W + 5;
  localparam int CNT_W = $clog2(DVD_W);
  localparam int SUM_W = DVD_W + 8;

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN} state_t;

  function automatic logic [7:0] sym_of(input logic [1:0] m);
    case (m)
      2'd2:    return 8'(SYM_US * 2);
      2'd3:    return 8'(SYM_US * 4);
      default: return 8'(SYM_US);
    endcase
  endfunction

  function automatic logic [7:0] pre_of(input logic [1:0] m);
    case (m)
      2'd1:    return 8'(PRE_WIDE_US);
      2'd2:    return 8'(PRE_US * 2);
      2'd3:    return 8'(PRE_US * 4);
      default: return 8'(PRE_US);
    endcase
  endfunction

  function automatic logic [7:0] sifs_of(input logic [1:0] m);
    case (m)
      2'd1:    return 8'(SIFS_WIDE_US);
      2'd2:    return 8'(SIFS_HALF_US);
      2'd3:    return 8'(SIFS_QTR_US);
      default: return 8'(SIFS_US);
    endcase
  endfunction

  state_t             st;
  logic [DVD_W-1:0]   dvd_q;
  logic [DSR_W-1:0]   rem_q;
  logic [DSR_W-1:0]   dsr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [1:0]         bw_q;

  logic [DVD_W-1:0]   bits_w, dvd_ld;
  logic [DSR_W-1:0]   dsr_ld;
  logic [DSR_W:0]     trial;
  logic               fits;
  logic [DVD_W:0]     syms;
  logic [SUM_W-1:0]   total;

  assign bits_w = DVD_W'(PLCP_BITS) + (DVD_W'(len_bytes) << 3);
  assign dvd_ld = (bits_w << 3) + (bits_w << 1);
  assign dsr_ld = DSR_W'(rate) * DSR_W'(sym_of(bw_mode));

  assign trial  = {rem_q, dvd_q[DVD_W-1]};
  assign fits   = trial >= {1'b0, dsr_q};

  assign syms   = {1'b0, dvd_q} + (DVD_W+1)'(|rem_q);
  assign total  = SUM_W'(sifs_of(bw_q)) + SUM_W'(pre_of(bw_q))
                + SUM_W'(syms) * SUM_W'(sym_of(bw_q));

  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      dvd_q    <= '0;
      rem_q    <= '0;
      dsr_q    <= '0;
      cnt_q    <= '0;
      bw_q     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      duration <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (rate == '0) begin
            done     <= 1'b1;
            err      <= 1'b1;
            duration <= '0;
          end else begin
            dvd_q <= dvd_ld;
            dsr_q <= dsr_ld;
            rem_q <= '0;
            cnt_q <= '0;
            bw_q  <= bw_mode;
            st    <= S_DIV;
          end
        end
        S_DIV: begin
          rem_q <= fits ? DSR_W'(trial - {1'b0, dsr_q}) : DSR_W'(trial);
          dvd_q <= {dvd_q[DVD_W-2:0], fits};
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(DVD_W - 1)) st <= S_FIN;
        end
        S_FIN: begin
          duration <= (|total[SUM_W-1:DUR_W]) ? '1 : total[DUR_W-1:0];
          err      <= 1'b0;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    if (!ack_high)              ack_rate_idx = (tx_rate_idx < 4'd4) ? 4'd0 : 4'd4;
    else if (tx_rate_idx == 0)  ack_rate_idx = 4'd0;
    else if (tx_rate_idx < 4)   ack_rate_idx = 4'd1;
    else if (tx_rate_idx < 6)   ack_rate_idx = 4'd4;
    else if (tx_rate_idx < 8)   ack_rate_idx = 4'd6;
    else                        ack_rate_idx = 4'd8;
  end
endmodule

// File: rtl/airtime_calc_chk.sv
module airtime_calc_chk #(
  parameter int RATE_W = 10,
  parameter int DUR_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [RATE_W-1:0] rate,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [DUR_W-1:0]  duration,
  input logic [3:0]        tx_rate_idx,
  input logic [3:0]        ack_rate_idx
);
  assert_one_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && rate != '0) |=> (busy && !done));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(duration));

  assert_zero_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && rate == '0) |=> (done && err && duration == '0));

  assert_ack_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rate_idx <= tx_rate_idx && ack_rate_idx <= 4'd8);
endmodule

bind airtime_calc airtime_calc_chk #(.RATE_W(RATE_W), .DUR_W(DUR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rate(rate), .busy(busy),
  .done(done), .err(err), .duration(duration),
  .tx_rate_idx(tx_rate_idx), .ack_rate_idx(ack_rate_idx));

// File: tb/airtime_calc_test.sv
`timescale 1ns/1ps
module airtime_calc_test;
  localparam int LEN_W  = 12;
  localparam int RATE_W = 10;

  logic clk = 0, rst_n = 0, start = 0, ack_high = 0;
  logic [LEN_W-1:0]  len_bytes = '0;
  logic [RATE_W-1:0] rate = '0;
  logic [1:0]        bw_mode = '0;
  logic [3:0]        tx_rate_idx = '0;
  logic              busy, done, err;
  logic [15:0]       duration;
  logic [3:0]        ack_rate_idx;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  airtime_calc uut (.clk(clk), .rst_n(rst_n), .start(start), .len_bytes(len_bytes),
    .rate(rate), .bw_mode(bw_mode), .tx_rate_idx(tx_rate_idx), .ack_high(ack_high),
    .busy(busy), .done(done), .err(err), .duration(duration), .ack_rate_idx(ack_rate_idx));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      report();
    end
  end

  function automatic longint exp_dur(input int l, input int r, input int b);
    longint sym, pre, sifs, dvd, dsr, n, t;
    sym  = (b == 2) ? 8 : (b == 3) ? 16 : 4;
    pre  = (b == 1) ? 14 : (b == 2) ? 40 : (b == 3) ? 80 : 20;
    sifs = (b == 1) ? 8 : (b == 2) ? 32 : (b == 3) ? 64 : 16;
    if (r == 0) return 0;
    dvd = (22 + 8 * longint'(l)) * 10;
    dsr = longint'(r) * sym;
    n   = (dvd + dsr - 1) / dsr;
    t   = sifs + pre + sym * n;
    return (t > 65535) ? 65535 : t;
  endfunction

  task automatic run(input int l, input int r, input int b, input string req);
    int lat;
    longint e;
    @(negedge clk);
    len_bytes = LEN_W'(l); rate = RATE_W'(r); bw_mode = 2'(b); start = 1;
    @(negedge clk);
    start = 0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    e = exp_dur(l, r, b);
    chk(duration == 16'(e), req, duration, e);
    chk(err == (r == 0), "R5 err flag", err, (r == 0));
    chk(lat == ((r == 0) ? 1 : LEN_W + 10), "R7 latency", lat, (r == 0) ? 1 : LEN_W + 10);
  endtask

  function automatic int exp_ack(input int i, input bit hi);
    if (!hi) return (i < 4) ? 0 : 4;
    if (i == 0) return 0;
    if (i < 4)  return 1;
    if (i < 6)  return 4;
    if (i < 8)  return 6;
    return 8;
  endfunction

  initial begin
    int rates[13] = '{1, 5, 7, 10, 20, 55, 60, 90, 120, 240, 480, 540, 1023};
    int lens[7]   = '{0, 1, 10, 14, 100, 1500, 4095};
    string bw_req[4] = '{"R1 20MHz", "R2 40MHz", "R3 10MHz", "R3 5MHz"};
    #1;
    chk(!busy && !done && !err && duration == 0, "R11 reset state", {busy, done, err}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    run(1, 5, 0, "R4 exact quotient");
    run(1, 7, 0, "R4 rounded quotient");
    run(14, 60, 0, "R4 ack-length frame");
    run(200, 0, 0, "R5 zero rate");
    run(4095, 1, 3, "R6 saturation");
    run(4095, 1, 0, "R6 saturation 20MHz");

    for (int b = 0; b < 4; b++)
      for (int ri = 0; ri < 13; ri++)
        for (int li = 0; li < 7; li++)
          run(lens[li], rates[ri], b, (exp_dur(lens[li], rates[ri], b) == 65535) ? "R6 sweep" : bw_req[b]);

    for (int l = 0; l < 64; l++) run(l, 13, l % 4, "R4 dense length sweep");

    @(negedge clk);
    len_bytes = 100; rate = 60; bw_mode = 0; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    len_bytes = 4000; rate = 1; bw_mode = 3; start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    chk(duration == 16'(exp_dur(100, 60, 0)), "R8 start while busy", duration, exp_dur(100, 60, 0));
    @(negedge clk);
    chk(!done, "R7 single-cycle done", done, 0);
    chk(!busy, "R8 second start not queued", busy, 0);
    repeat (5) @(negedge clk);
    chk(duration == 16'(exp_dur(100, 60, 0)), "R7 result held", duration, exp_dur(100, 60, 0));

    for (int h = 0; h < 2; h++)
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        ack_high = h[0]; tx_rate_idx = 4'(i);
        #1;
        chk(ack_rate_idx == 4'(exp_ack(i, h[0])), h ? "R9 high ack map" : "R10 base ack map",
            ack_rate_idx, exp_ack(i, h[0]));
      end

    report();
  end
endmodule